// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Character FIFO

This block turns a stream of 8-bit characters into an asynchronous serial line. Characters arrive on a valid/ready input and wait in a first-in first-out buffer of `DEPTH` entries, 64 by default. A shift stage takes them out one at a time and sends each as a self-framed character. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between characters.

The frame format comes from three plain configuration inputs: data length 7 or 8 bits, stop length 1 or 2 bits, and parity even, odd or none. It is read at the moment a character leaves the buffer. Bit timing comes from an external `baud_tick` strobe: each bit lasts `TICKS_PER_BIT` (16) strobes. An active-low clear-to-send input, `cts_n`, gates the start of each new character. A character already on the line always completes.

Back-pressure rules on the input: a beat is accepted on a clock where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the buffer holds fewer than `DEPTH` characters, even on a clock where a character is being taken out. A producer that offers a beat while `in_ready` is low loses that beat and sets the sticky `overflow` flag. The flag stays set until reset.

Top module: `ser_tx_fifo`

## Requirements
- R1: After reset: `txd`=1, `fifo_level`=0, `fifo_empty`=1, `tx_idle`=1, `in_ready`=1 and `overflow`=0.
- R2: A character is a 0 start bit, then the data bits LSB first, then the parity bit when enabled, then the stop bits at 1. The start bit appears on the clock after the character is taken, and the line is 1 whenever no character is in progress.
- R3: `cfg_len8`=1 sends all 8 bits of a character. `cfg_len8`=0 sends bits 6..0 only, and bit 7 is neither sent nor counted for parity.
- R4: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two.
- R5: `cfg_parity` coding: 2'b00 no parity bit, 2'b01 even, 2'b10 odd, 2'b11 no parity bit. Even parity makes the count of ones over the data and parity bits even; odd parity makes that count odd.
- R6: Each bit lasts exactly `TICKS_PER_BIT` (16) clocks with `baud_tick` high. During a character, `txd` changes only on such a clock. The start bit itself begins without waiting for a tick.
- R7: The buffer returns characters in the order they were accepted and holds up to 64 of them. `fifo_level` is the count held, `fifo_empty` is high at count 0, and `in_ready` is high exactly when the count is below 64.
- R8: A beat offered with `in_valid`=1 while `in_ready`=0 is discarded and is never sent. It sets `overflow` on the next clock, and `overflow` stays 1 until reset.
- R9: While `cts_n`=1 no new character starts. A character already started runs to its last stop bit.
- R10: `tx_idle` is high only when the buffer is empty and no character is on the line. It rises on the clock that ends the last stop bit.
- R11: With characters waiting and `cts_n`=0, the next start bit begins one clock after the previous last stop bit ends. With a tick on every clock, consecutive start bits are 16·n+1 clocks apart for an n-bit frame.
- R12: The frame format is captured when a character is taken. Changing the configuration inputs during a character affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Buffer can accept a character |
| in_data | input | 8 | Character to send |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| cts_n | input | 1 | Clear to send, active low; gates character starts |
| baud_tick | input | 1 | One strobe per sixteenth of a bit |
| txd | output | 1 | Serial line, idles high |
| fifo_level | output | 7 | Characters held in the buffer |
| fifo_empty | output | 1 | Buffer holds no character |
| tx_idle | output | 1 | Buffer empty and line at rest |
| overflow | output | 1 | Sticky: a beat was refused |

## Verification
The bound checker watches, on every clock, the properties that hold for any input: the line stays high when idle, `txd` does not move during a character without a tick, no character starts while `cts_n` is high, and `in_ready` falls only at a full buffer. It also checks that a refused beat sets `overflow`, that the flag never clears, and that the level moves by at most one per clock. Bit contents, parity values, stop-bit counts, ordering through a full buffer, frame spacing and the exact clock on which `tx_idle` rises depend on the data and the format. Only the bench's decoding of the line, swept over all sixteen format codes, can show those.

// File: rtl/stx_pkg.sv
package stx_pkg;

  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned FRAME_W = 12;  // start + 8 data + parity + 2 stop
  localparam int unsigned NBITS_W = 4;

  typedef enum logic [1:0] {
    PAR_OFF     = 2'b00,
    PAR_EVEN    = 2'b01,
    PAR_ODD     = 2'b10,
    PAR_OFF_ALT = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic      len8;
    logic      stop2;
    par_mode_e par;
  } fmt_t;

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import stx_pkg::*;
(
  input  logic [CHAR_W-1:0]  data,
  input  fmt_t               fmt,
  output logic [FRAME_W-1:0] frame,
  output logic [NBITS_W-1:0] nbits
);

  logic has_par, ones, par_bit;

  assign has_par = (fmt.par == PAR_EVEN) || (fmt.par == PAR_ODD);
  assign ones    = fmt.len8 ? ^data : ^data[6:0];
  assign par_bit = (fmt.par == PAR_ODD) ? ~ones : ones;

  // Unused upper positions stay 1 so that they read as stop/idle level.
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 7; i++) frame[1+i] = data[i];
    if (fmt.len8) begin
      frame[8] = data[7];
      if (has_par) frame[9] = par_bit;
    end else if (has_par) begin
      frame[8] = par_bit;
    end
  end

  // start + 7 data + 1 stop = 9, plus the optional extras
  assign nbits = NBITS_W'(9) + NBITS_W'(fmt.len8) + NBITS_W'(has_par)
               + NBITS_W'(fmt.stop2);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int FW   = 12,
  parameter int NBW  = 4,
  parameter int TPB  = 16,
  localparam int TW  = (TPB > 1) ? $clog2(TPB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           baud_tick,
  input  logic           start_ok,
  input  logic [FW-1:0]  frame,
  input  logic [NBW-1:0] nbits,
  output logic           take,
  output logic           busy,
  output logic           txd
);

  logic [FW-1:0]  sh;
  logic [NBW-1:0] left;
  logic [TW-1:0]  tcnt;
  logic           bit_end;

  assign take    = !busy && start_ok;
  assign bit_end = baud_tick && (tcnt == TW'(TPB - 1));
  assign txd     = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else if (take) begin
      busy <= 1'b1;
      sh   <= frame;
      left <= nbits;
      tcnt <= '0;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - NBW'(1);
        if (left == NBW'(1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

endmodule

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo
  import stx_pkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int TICKS_PER_BIT = 16,
  localparam int LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              cfg_len8,
  input  logic              cfg_stop2,
  input  logic [1:0]        cfg_parity,
  input  logic              cts_n,
  input  logic              baud_tick,
  output logic              txd,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_empty,
  output logic              tx_idle,
  output logic              overflow
);

  logic [CHAR_W-1:0]  head;
  logic               full, take, sh_busy;
  logic [FRAME_W-1:0] frame;
  logic [NBITS_W-1:0] nbits;
  fmt_t               fmt;

  assign fmt      = '{len8: cfg_len8, stop2: cfg_stop2, par: par_mode_e'(cfg_parity)};
  assign in_ready = !full;
  assign tx_idle  = fifo_empty && !sh_busy;

  stx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_data (in_data),
    .rd_en   (take),
    .rd_data (head),
    .count   (fifo_level),
    .full    (full),
    .empty   (fifo_empty)
  );

  stx_framer u_framer (
    .data  (head),
    .fmt   (fmt),
    .frame (frame),
    .nbits (nbits)
  );

  stx_shifter #(.FW(FRAME_W), .NBW(NBITS_W), .TPB(TICKS_PER_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .start_ok  (!fifo_empty && !cts_n),
    .frame     (frame),
    .nbits     (nbits),
    .take      (take),
    .busy      (sh_busy),
    .txd       (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     overflow <= 1'b0;
    else if (in_valid && !in_ready) overflow <= 1'b1;
  end

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             cts_n,
  input logic             baud_tick,
  input logic             txd,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_empty,
  input logic             tx_idle,
  input logic             overflow,
  input logic             busy
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd); // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !txd); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (busy && !baud_tick) |=> $stable(txd)); // R6
  AST_READY_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n) !in_ready |-> (fifo_level == LVL_W'(DEPTH))); // R7
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (fifo_level == $past(fifo_level) || fifo_level == $past(fifo_level) + LVL_W'(1) || fifo_level + LVL_W'(1) == $past(fifo_level))); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_ready) |=> overflow); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R8
  AST_CTS_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n) (cts_n && !busy) |=> !busy); // R9
  AST_IDLE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_idle |-> (fifo_empty && !busy)); // R10

endmodule

bind ser_tx_fifo stx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cts_n      (cts_n),
  .baud_tick  (baud_tick),
  .txd        (txd),
  .fifo_level (fifo_level),
  .fifo_empty (fifo_empty),
  .tx_idle    (tx_idle),
  .overflow   (overflow),
  .busy       (sh_busy)
);

// File: tb/tb_ser_tx_fifo.sv
`timescale 1ns/1ps
module tb_ser_tx_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       cfg_len8 = 1'b1, cfg_stop2 = 1'b0;
  logic [1:0] cfg_parity = 2'b00;
  logic       cts_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       in_ready, txd, fifo_empty, tx_idle, overflow;
  logic [6:0] fifo_level;

  ser_tx_fifo dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_len8(cfg_len8), .cfg_stop2(cfg_stop2),
    .cfg_parity(cfg_parity), .cts_n(cts_n), .baud_tick(tick_en), .txd(txd),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .tx_idle(tx_idle),
    .overflow(overflow)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // Line decoder: samples each bit at its middle, format read at start.
  bit          mon_en = 1'b1;
  int          q_t0[$];
  logic [11:0] q_bits[$];
  int          m_t0, m_nb;
  logic [11:0] m_rb;

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && txd === 1'b0) begin
        m_t0 = cyc;
        m_nb = 1 + (cfg_len8 ? 8 : 7) + ((cfg_parity == 2'b01 || cfg_parity == 2'b10) ? 1 : 0)
             + (cfg_stop2 ? 2 : 1);
        m_rb = '1;
        repeat (8) @(negedge clk);
        for (int b = 0; b < m_nb; b++) begin
          m_rb[b] = txd;
          if (b < m_nb - 1) repeat (16) @(negedge clk);
        end
        q_t0.push_back(m_t0);
        q_bits.push_back(m_rb);
      end
    end
  end

  function automatic int frame_len(input bit l8, input bit s2, input logic [1:0] pm);
    return 1 + (l8 ? 8 : 7) + ((pm == 2'b01 || pm == 2'b10) ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  task automatic push1(input logic [7:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    while (q_t0.size() < n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!tx_idle) @(negedge clk);
  endtask

  task automatic clear_q();
    q_t0.delete();
    q_bits.delete();
  endtask

  task automatic check_frame(input logic [7:0] d, input bit l8, input bit s2,
                             input logic [1:0] pm, input int k);
    int          fl, hp, ns;
    logic [11:0] rb, ad, as;
    logic [7:0]  ed;
    bit          ep;
    fl = l8 ? 8 : 7;
    hp = (pm == 2'b01 || pm == 2'b10) ? 1 : 0;
    ns = s2 ? 2 : 1;
    rb = q_bits[k];
    chk(rb[0] == 1'b0, "R2 start bit", rb[0], 0);
    ed = l8 ? d : (d & 8'h7F);
    ad = (rb >> 1) & (l8 ? 12'h0FF : 12'h07F);
    chk(ad == 12'(ed), "R3 data field", ad, ed);
    if (hp == 1) begin
      ep = ($countones(ed) % 2) == 1;
      if (pm == 2'b10) ep = !ep;
      chk(rb[1+fl] == ep, "R5 parity bit", rb[1+fl], ep);
    end
    as = (rb >> (1 + fl + hp)) & 12'((1 << ns) - 1);
    chk(as == 12'((1 << ns) - 1), "R4 stop bits", as, (1 << ns) - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] dv[4];
    int         nb, c0, k;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(fifo_level == 0, "R1 fifo_level", fifo_level, 0);
    chk(fifo_empty == 1'b1, "R1 fifo_empty", fifo_empty, 1);
    chk(tx_idle == 1'b1, "R1 tx_idle", tx_idle, 1);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);

    // R2..R5, R10, R11: sweep of all sixteen format codes
    for (int f = 0; f < 16; f++) begin
      cfg_len8   = f[0];
      cfg_stop2  = f[1];
      cfg_parity = f[3:2];
      nb = frame_len(f[0], f[1], f[3:2]);
      dv[0] = 8'h00;
      dv[1] = 8'hFF;
      dv[2] = 8'hA5 ^ {f[3:0], f[3:0]};
      dv[3] = 8'h80 | 8'(f * 7);
      clear_q();
      for (int i = 0; i < 4; i++) push1(dv[i]);
      wait_frames(4);
      for (int i = 0; i < 4; i++) check_frame(dv[i], f[0], f[1], f[3:2], i);
      for (int i = 0; i < 3; i++)
        chk(q_t0[i+1] - q_t0[i] == 16 * nb + 1, "R11 start spacing",
            q_t0[i+1] - q_t0[i], 16 * nb + 1);
      chk(tx_idle == 1'b0, "R10 busy during last frame", tx_idle, 0);
      wait_idle();
      chk(cyc == q_t0[3] + 16 * nb, "R10 idle rise cycle", cyc, q_t0[3] + 16 * nb);
      repeat (3) @(negedge clk);
    end

    // R7, R8, R9: fill while clear-to-send is withheld
    cfg_len8 = 1'b1; cfg_stop2 = 1'b0; cfg_parity = 2'b00;
    clear_q();
    cts_n = 1'b1;
    for (int i = 0; i < 64; i++) push1(8'(i * 3 + 1));
    repeat (2) @(negedge clk);
    chk(fifo_level == 64, "R7 level at full", fifo_level, 64);
    chk(in_ready == 1'b0, "R7 in_ready at full", in_ready, 0);
    chk(txd == 1'b1, "R9 no start while cts_n high", txd, 1);
    chk(overflow == 1'b0, "R8 no flag before refused beat", overflow, 0);
    push1(8'hEE);
    chk(overflow == 1'b1, "R8 flag after refused beat", overflow, 1);
    chk(fifo_level == 64, "R8 level unchanged", fifo_level, 64);
    cts_n = 1'b0;
    wait_frames(64);
    for (int i = 0; i < 64; i++) begin
      k = 0;
      check_frame(8'(i * 3 + 1), 1'b1, 1'b0, 2'b00, i);
    end
    wait_idle();
    repeat (200) @(negedge clk);
    chk(q_t0.size() == 64, "R8 refused beat never sent", q_t0.size(), 64);
    chk(overflow == 1'b1, "R8 flag sticky", overflow, 1);
    chk(fifo_level == 0, "R7 drained", fifo_level, 0);

    // R9: withdraw clear-to-send during a character
    clear_q();
    push1(8'h5A);
    push1(8'hC3);
    while (txd) @(negedge clk);
    repeat (20) @(negedge clk);
    cts_n = 1'b1;
    repeat (400) @(negedge clk);
    chk(q_t0.size() == 1, "R9 only started frame sent", q_t0.size(), 1);
    chk(fifo_level == 1, "R9 second char held", fifo_level, 1);
    chk(tx_idle == 1'b0, "R10 not idle with char held", tx_idle, 0);
    chk(txd == 1'b1, "R9 line high while held", txd, 1);
    check_frame(8'h5A, 1'b1, 1'b0, 2'b00, 0);
    cts_n = 1'b0;
    wait_frames(2);
    check_frame(8'hC3, 1'b1, 1'b0, 2'b00, 1);
    wait_idle();
    repeat (3) @(negedge clk);

    // R12: format change in the middle of a character
    clear_q();
    push1(8'h3C);
    while (txd) @(negedge clk);
    repeat (30) @(negedge clk);
    cfg_len8 = 1'b0; cfg_stop2 = 1'b1; cfg_parity = 2'b10;
    wait_frames(1);
    check_frame(8'h3C, 1'b1, 1'b0, 2'b00, 0);
    wait_idle();
    chk(cyc == q_t0[0] + 16 * 10, "R12 old frame length kept", cyc, q_t0[0] + 160);
    push1(8'hB7);
    wait_frames(2);
    check_frame(8'hB7, 1'b0, 1'b1, 2'b10, 1);
    wait_idle();
    repeat (3) @(negedge clk);

    // R6: bit timing follows baud_tick only
    cfg_len8 = 1'b1; cfg_stop2 = 1'b0; cfg_parity = 2'b00;
    mon_en  = 1'b0;
    tick_en = 1'b0;
    push1(8'h01);
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R6 start without tick", txd, 0);
    repeat (100) @(negedge clk);
    chk(txd == 1'b0, "R6 start held with no ticks", txd, 0);
    c0 = cyc;
    tick_en = 1'b1;
    while (!txd && cyc < c0 + 100) @(negedge clk);
    chk(cyc == c0 + 16, "R6 start bit lasts 16 ticks", cyc - c0, 16);
    wait_idle();
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule